// File: doc/BRIEF.md
# Stepped Logarithmic Stereo Volume Attenuator

This block scales a stereo stream of signed 18-bit samples by a gain chosen from a 7-bit code in 1 dB steps. Code 0x79 is unity gain, 0x7F is +6 dB and 0x15 is -100 dB. Every code at or below 0x14 silences the output. A new target code is not applied at once. The block walks its current code toward the target one step at a time, with a programmable dwell of 1 to 128 sample periods per step, so that volume changes do not produce clicks.

A mute request or a sync-loss flag forces the effective target to silence, so the gain ramps down. When the cause clears, the gain ramps back to the stored target. A parallel-mode flag replaces the stored target with unity gain. Mute and sync loss still act in that mode. Samples enter on a one-cycle strobe at the sample rate. The scaled pair is registered on that same strobe.

Top module: `gain_stepper`

## Requirements
- R1: While reset is low and after it is released, `cur_code` is 0 and both sample outputs are 0.
- R2: The gain in dB is `cur_code` - 121. `cur_code` only ever holds 0 or a value from 0x15 to 0x7F. A target of 0x14 or below is treated as 0 (silence).
- R3: On each `smp_stb`, each output register takes floor(x*M[r] / 2^(15+q)). Here d = 127 - c, q = d/6 and r = d%6, and c is the `cur_code` value held in that strobe cycle, before any step. M = {65536, 58409, 52057, 46396, 41350, 36854}. The result saturates to the range -131072 to 131071. When c is 0 the output is 0.
- R4: `cur_code` changes only on a strobe cycle, and by one step. A step happens on every 2^`dwell_sel`-th strobe while the code differs from the effective target. With `dwell_sel` 0 the first strobe steps.
- R5: A downward step from 0x15 goes to 0. An upward step from 0 goes to 0x15.
- R6: The dwell count restarts from zero when the effective target changes direction relative to the current code. The count is also held at zero while the code equals the target.
- R7: While `mute_req` is high the effective target is 0. When it goes low the code ramps back to the stored target.
- R8: While `sync_lost` is high the effective target is 0. When it goes low the code ramps back to the stored target.
- R9: While `fixed_unity` is high the effective target is 0x79, whatever `target_code` holds. Mute and sync loss still override it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe, once per sample period |
| left_in | input | 18 | Signed left sample, valid with the strobe |
| right_in | input | 18 | Signed right sample, valid with the strobe |
| target_code | input | 7 | Stored attenuation target code |
| dwell_sel | input | 3 | Step dwell select: 2^value strobes per step |
| mute_req | input | 1 | Ramp to silence while high |
| sync_lost | input | 1 | Ramp to silence while high |
| fixed_unity | input | 1 | Use a 0 dB target instead of `target_code` |
| left_out | output | 18 | Scaled left sample |
| right_out | output | 18 | Scaled right sample |
| cur_code | output | 7 | Current attenuation code |

## Verification
The bench targets the jump across the silence threshold. A design that stepped through 0x14..0x01 would take extra strobes to leave or reach silence. It also drives a direction reversal halfway through a dwell: a timer that was not restarted steps early. The bench pushes +6 dB with full-scale input, where a missing saturation wraps the sign. It runs the 128-strobe dwell to its last strobe, where an undersized timer steps early or never. It checks the parallel flag with a target below the floor; a design that ignored the flag would stay silent.

// File: rtl/gain_stepper.sv
module gain_stepper #(
  parameter int DW = 18,
  parameter int CW = 7,
  parameter int SW = 3,
  parameter logic [CW-1:0] FLOOR = 7'h14,
  parameter logic [CW-1:0] UNITY = 7'h79
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] left_in,
  input  logic signed [DW-1:0] right_in,
  input  logic [CW-1:0]        target_code,
  input  logic [SW-1:0]        dwell_sel,
  input  logic                 mute_req,
  input  logic                 sync_lost,
  input  logic                 fixed_unity,
  output logic signed [DW-1:0] left_out,
  output logic signed [DW-1:0] right_out,
  output logic [CW-1:0]        cur_code
);
  localparam int TMW = (1 << SW) - 1;
  localparam int PW = DW + 18;
  localparam logic [CW-1:0] TOP = '1;
  localparam logic [CW-1:0] FIRST = FLOOR + 1'b1;
  localparam logic [TMW-1:0] ONE = 1;
  localparam logic signed [PW-1:0] PMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN = ~PMAX;

  logic [TMW-1:0] tmr;
  logic           dir_q;

  wire [CW-1:0] req  = fixed_unity ? UNITY : target_code;
  wire [CW-1:0] goal = (mute_req || sync_lost || req <= FLOOR) ? '0 : req;
  wire moving = cur_code != goal;
  wire go_up  = goal > cur_code;
  wire [TMW-1:0] last = (ONE << dwell_sel) - ONE;
  wire [CW-1:0] nxt = go_up ? ((cur_code == '0) ? FIRST : cur_code + 1'b1)
                            : ((cur_code == FIRST) ? '0 : cur_code - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_code <= '0;
      tmr      <= '0;
      dir_q    <= 1'b0;
    end else if (!moving) begin
      tmr <= '0;
    end else if (go_up != dir_q) begin
      dir_q <= go_up;
      tmr   <= '0;
    end else if (smp_stb) begin
      if (tmr >= last) begin
        cur_code <= nxt;
        tmr      <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                  input logic [CW-1:0] c);
    logic [CW-1:0] d, q, r;
    logic [16:0] m;
    logic signed [PW-1:0] p;
    d = TOP - c;
    q = d / CW'(6);
    r = d % CW'(6);
    case (r)
      CW'(0):  m = 17'd65536;
      CW'(1):  m = 17'd58409;
      CW'(2):  m = 17'd52057;
      CW'(3):  m = 17'd46396;
      CW'(4):  m = 17'd41350;
      default: m = 17'd36854;
    endcase
    p = PW'(x) * $signed({1'b0, m});
    p = p >>> (15 + int'(q));
    if (p > PMAX)      scale = PMAX[DW-1:0];
    else if (p < PMIN) scale = PMIN[DW-1:0];
    else               scale = p[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_out  <= '0;
      right_out <= '0;
    end else if (smp_stb) begin
      left_out  <= (cur_code == '0) ? '0 : scale(left_in, cur_code);
      right_out <= (cur_code == '0) ? '0 : scale(right_in, cur_code);
    end
  end

  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code == '0) || (cur_code > FLOOR));

  a_r4_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(cur_code));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (cur_code == $past(cur_code)) || (cur_code == $past(cur_code) + 1'b1) ||
                (cur_code == $past(cur_code) - 1'b1) ||
                (cur_code == FIRST && $past(cur_code) == '0) ||
                (cur_code == '0 && $past(cur_code) == FIRST));

  a_r7_mute_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> cur_code <= $past(cur_code));

  a_r8_sync_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> cur_code <= $past(cur_code));

  a_r3_silent_out: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && cur_code == '0) |=> (left_out == '0 && right_out == '0));
endmodule

// File: tb/sim_gain_stepper.sv
module sim_gain_stepper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic signed [17:0] lin = '0, rin = '0;
  logic [6:0] tgt = '0;
  logic [2:0] sel = '0;
  logic mute = 1'b0, slost = 1'b0, unity = 1'b0;
  logic signed [17:0] lout, rout;
  logic [6:0] code;

  int n_chk = 0, n_fail = 0, k = 0;
  int exp_l[$];
  int exp_r[$];

  always #2 clk = ~clk;

  gain_stepper u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(stb), .left_in(lin), .right_in(rin),
    .target_code(tgt), .dwell_sel(sel), .mute_req(mute), .sync_lost(slost),
    .fixed_unity(unity), .left_out(lout), .right_out(rout), .cur_code(code));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int c, input int x);
    int m[6] = '{65536, 58409, 52057, 46396, 41350, 36854};
    int d;
    longint p;
    if (c < 'h15) return 0;
    d = 127 - c;
    p = longint'(x) * m[d % 6];
    p = p >>> (15 + d / 6);
    if (p > 131071) p = 131071;
    if (p < -131072) p = -131072;
    return int'(p);
  endfunction

  task automatic strobe(input int l, input int r);
    @(negedge clk);
    lin = 18'(l);
    rin = 18'(r);
    exp_l.push_back(model(int'(code), l));
    exp_r.push_back(model(int'(code), r));
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      k++;
      strobe(((k * 7919) % 262144) - 131072, 131071 - ((k * 104729) % 262144));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: R3 on every strobed sample
  always @(posedge clk) begin
    if (stb && rst_n) begin
      #1;
      check("R3 left", int'(lout), exp_l.pop_front());
      check("R3 right", int'(rout), exp_r.pop_front());
    end
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(5);
    check("R1 code in reset", int'(code), 0);
    check("R1 left in reset", int'(lout), 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 code after reset", int'(code), 0);
    check("R1 right after reset", int'(rout), 0);

    tgt = 7'h79; idle(2);
    strobes(1);   check("R5 leave silence", int'(code), 'h15);
    strobes(100); check("R4 ramp to unity", int'(code), 'h79);
    strobe(12345, -100000);
    check("R3 unity left", int'(lout), 12345);
    check("R3 unity right", int'(rout), -100000);

    tgt = 7'h7F; idle(2);
    strobes(6); check("R2 top code", int'(code), 'h7F);
    strobe(100000, -100000);
    check("R3 saturate high", int'(lout), 131071);
    check("R3 saturate low", int'(rout), -131072);

    sel = 3'd2; tgt = 7'h79; idle(2);
    strobes(3);  check("R4 dwell 4 wait", int'(code), 'h7F);
    strobes(1);  check("R4 dwell 4 step", int'(code), 'h7E);
    strobes(20); check("R4 dwell 4 done", int'(code), 'h79);

    tgt = 7'h70; idle(2);
    strobes(2); check("R6 before reverse", int'(code), 'h79);
    tgt = 7'h7F; idle(2);
    strobes(3); check("R6 restart held", int'(code), 'h79);
    strobes(1); check("R6 restart step", int'(code), 'h7A);

    sel = 3'd0; tgt = 7'h16; idle(2);
    strobes(100); check("R4 down to 0x16", int'(code), 'h16);
    mute = 1'b1; idle(2);
    strobes(1); check("R7 mute step", int'(code), 'h15);
    strobes(1); check("R5 drop to silence", int'(code), 0);
    strobe(5000, -5000);
    check("R7 muted left", int'(lout), 0);
    check("R7 muted right", int'(rout), 0);
    mute = 1'b0; idle(2);
    strobes(2); check("R7 release", int'(code), 'h16);

    slost = 1'b1; idle(2);
    strobes(2); check("R8 sync loss", int'(code), 0);
    strobes(3); check("R8 stays silent", int'(code), 0);
    slost = 1'b0; idle(2);
    strobes(2); check("R8 restore", int'(code), 'h16);

    tgt = 7'h10; idle(2);
    strobes(1); check("R5 to 0x15", int'(code), 'h15);
    strobes(1); check("R5 below floor", int'(code), 0);
    strobes(5); check("R2 floor target stays", int'(code), 0);

    tgt = 7'h79;
    idle(20); check("R4 no strobe no step", int'(code), 0);

    tgt = 7'h10; unity = 1'b1; idle(2);
    strobes(101); check("R9 unity target", int'(code), 'h79);
    strobe(777, -777);
    check("R9 unity left", int'(lout), 777);
    check("R9 unity right", int'(rout), -777);
    mute = 1'b1; idle(2);
    strobes(101); check("R9 mute overrides", int'(code), 0);
    mute = 1'b0; idle(2);
    strobes(101); check("R9 back to unity", int'(code), 'h79);
    tgt = 7'h79; unity = 1'b0; idle(2);

    sel = 3'd7; tgt = 7'h78; idle(2);
    strobes(127); check("R4 dwell 128 wait", int'(code), 'h79);
    strobes(1);   check("R4 dwell 128 step", int'(code), 'h78);
    strobe(1000, -1000);
    check("R3 minus 1 dB left", int'(lout), 891);
    check("R3 minus 1 dB right", int'(rout), -892);

    idle(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule